// File: doc/BRIEF.md
# PCI Function Lifecycle Controller

This block follows one PCI function from the moment it is plugged in until it is released. It decides which commands are legal in each state. Commands arrive as single-cycle strobes. A strobe that the current state does not accept, or two or more strobes raised in the same cycle, leave the state alone and raise a one-cycle error pulse. Every output is registered, so the result of a strobe appears one edge after it is sampled.

The seven states are RESERVED, STANDBY, DISABLED, ENABLED, BLOCKED, ERROR and PERM_ERR. DISABLED, ENABLED, BLOCKED, ERROR and PERM_ERR together form the configured group.

The transitions are:
- plug (RESERVED to STANDBY)
- configure (STANDBY to DISABLED)
- deconfigure (configured group to STANDBY, or to RESERVED when an unplug is pending)
- enable (DISABLED to ENABLED)
- disable (ENABLED to DISABLED)
- block (ENABLED to BLOCKED)
- error report (ENABLED or BLOCKED to ERROR)
- modify (BLOCKED or ERROR to ENABLED)
- fatal (DISABLED, ENABLED, BLOCKED or ERROR to PERM_ERR)
- unplug in STANDBY (to RESERVED)
- unplug in the configured group (stays put and arms the release timer)
- timer expiry (to RESERVED)

The block drives a 32-bit function handle and a flag that permits DMA and interrupts. It also sends a hot-plug event code with a valid strobe on the transitions that the host must be told about. An unplug request that the guest leaves unanswered for `UNPLUG_CYCLES` cycles forces a release.

Top module: `fn_lifecycle_ctrl`

## Requirements
- R1: After reset the state is RESERVED (state code 0). `handle_o[31]` is 0 and the instance field is 0. `ev_valid_o`, `err_o` and `dma_ok_o` are all 0.
- R2: plug moves RESERVED to STANDBY with event 0x0302. configure moves STANDBY to DISABLED with event 0x0301.
- R3: enable moves DISABLED to ENABLED and adds one, modulo 128, to the instance field. disable moves ENABLED to DISABLED.
- R4: block moves ENABLED to BLOCKED. An error report moves ENABLED or BLOCKED to ERROR. modify moves BLOCKED or ERROR to ENABLED. None of these raises an event.
- R5: `dma_ok_o` is 1 only in ENABLED, so DMA and interrupts are refused in BLOCKED.
- R6: The handle has four fields. Bit 31 is 1 only in ENABLED, BLOCKED and ERROR. Bits 30:24 hold the instance count. Bits 23:16 hold the `FN_TYPE` parameter (0x01 passthrough, 0x02 emulated). Bits 15:0 hold the `FN_INDEX` parameter.
- R7: fatal moves DISABLED, ENABLED, BLOCKED or ERROR to PERM_ERR. From PERM_ERR only deconfigure is accepted.
- R8: deconfigure moves any configured state to STANDBY with event 0x0304.
- R9: Two kinds of strobe are illegal: one that the current state does not accept, and more than one strobe in a cycle. An illegal strobe leaves the state and handle unchanged, raises `err_o` for exactly one cycle and sends no event.
- R10: unplug in STANDBY moves to RESERVED with event 0x0308.
- R11: unplug in a configured state sends event 0x0303, keeps the state and marks an unplug pending. A second unplug while one is pending is illegal. A deconfigure while pending moves to RESERVED with event 0x0304.
- R12: Suppose an unplug is pending and no deconfigure arrives. Then the `UNPLUG_CYCLES`-th edge after the request was accepted moves the state to RESERVED with event 0x0304 and no error. Strobes in that cycle are ignored.
- R13: State, handle, `dma_ok_o`, event and error all change on the first edge after the strobe that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plug_i | input | 1 | Plug strobe |
| configure_i | input | 1 | Configure strobe |
| deconfigure_i | input | 1 | Deconfigure strobe |
| enable_i | input | 1 | Enable strobe |
| disable_i | input | 1 | Disable strobe |
| block_i | input | 1 | Block strobe |
| modify_i | input | 1 | Modify-controls (unblock/recover) strobe |
| err_report_i | input | 1 | Recoverable error report strobe |
| fatal_i | input | 1 | Unrecoverable error report strobe |
| unplug_i | input | 1 | Hot-unplug request strobe |
| state_o | output | 3 | Current state code (RESERVED=0 to PERM_ERR=6) |
| handle_o | output | 32 | Function handle |
| dma_ok_o | output | 1 | DMA and interrupts permitted |
| ev_valid_o | output | 1 | Hot-plug event strobe |
| ev_code_o | output | 16 | Hot-plug event code, 0 when no event |
| err_o | output | 1 | Illegal-command pulse |

## Verification
Each strobe is held for one cycle from a falling edge. Its state, handle, permit flag, event and error results are all due on the next rising edge. The driver therefore stamps each expected item with the cycle count plus one, and the monitor compares it on the falling edge that follows that rising edge. For the release timer the bench sends one idle item per cycle after the unplug request. The first `UNPLUG_CYCLES`-1 items expect no change, and the item due on the `UNPLUG_CYCLES`-th edge expects RESERVED with event 0x0304.

// File: rtl/fn_lc_pkg.sv
package fn_lc_pkg;

    typedef enum logic [2:0] {
        ST_RESERVED = 3'd0,
        ST_STANDBY  = 3'd1,
        ST_DISABLED = 3'd2,
        ST_ENABLED  = 3'd3,
        ST_BLOCKED  = 3'd4,
        ST_ERROR    = 3'd5,
        ST_PERM_ERR = 3'd6
    } fn_state_e;

    typedef struct packed {
        logic plug;
        logic cfg;
        logic decfg;
        logic en;
        logic dis;
        logic blk;
        logic modify;
        logic err_rep;
        logic fatal;
        logic unplug;
    } fn_cmd_t;

    localparam logic [15:0] EV_TO_CONFIGURED = 16'h0301;
    localparam logic [15:0] EV_RES_TO_STBY   = 16'h0302;
    localparam logic [15:0] EV_DECFG_REQ     = 16'h0303;
    localparam logic [15:0] EV_CFG_TO_STBY   = 16'h0304;
    localparam logic [15:0] EV_STBY_TO_RES   = 16'h0308;

    localparam int INST_W = 7;

endpackage

// File: rtl/fn_lc_fsm.sv
module fn_lc_fsm
    import fn_lc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fn_cmd_t     cmd,
    input  logic        pending,
    input  logic        expire,
    output fn_state_e   state_q,
    output logic        ev_valid_q,
    output logic [15:0] ev_code_q,
    output logic        err_q,
    output logic        arm,
    output logic        clr,
    output logic        inst_inc
);

    fn_state_e   nxt;
    logic        ev;
    logic [15:0] code;
    logic        ill;
    logic        in_cfg;
    logic        live;

    assign in_cfg = (state_q == ST_DISABLED) || (state_q == ST_ENABLED) ||
                    (state_q == ST_BLOCKED)  || (state_q == ST_ERROR)   ||
                    (state_q == ST_PERM_ERR);
    assign live   = in_cfg && (state_q != ST_PERM_ERR);

    always_comb begin
        nxt      = state_q;
        ev       = 1'b0;
        code     = '0;
        ill      = 1'b0;
        arm      = 1'b0;
        clr      = 1'b0;
        inst_inc = 1'b0;
        if (expire) begin
            nxt  = ST_RESERVED;
            ev   = 1'b1;
            code = EV_CFG_TO_STBY;
            clr  = 1'b1;
        end else if (cmd != '0) begin
            if (!$onehot(cmd)) begin
                ill = 1'b1;
            end else if (in_cfg && cmd.decfg) begin
                nxt  = pending ? ST_RESERVED : ST_STANDBY;
                clr  = pending;
                ev   = 1'b1;
                code = EV_CFG_TO_STBY;
            end else if (in_cfg && cmd.unplug) begin
                if (pending) begin
                    ill = 1'b1;
                end else begin
                    arm  = 1'b1;
                    ev   = 1'b1;
                    code = EV_DECFG_REQ;
                end
            end else if (live && cmd.fatal) begin
                nxt = ST_PERM_ERR;
            end else begin
                unique case (state_q)
                    ST_RESERVED: begin
                        if (cmd.plug) begin
                            nxt  = ST_STANDBY;
                            ev   = 1'b1;
                            code = EV_RES_TO_STBY;
                        end else ill = 1'b1;
                    end
                    ST_STANDBY: begin
                        if (cmd.cfg) begin
                            nxt  = ST_DISABLED;
                            ev   = 1'b1;
                            code = EV_TO_CONFIGURED;
                        end else if (cmd.unplug) begin
                            nxt  = ST_RESERVED;
                            ev   = 1'b1;
                            code = EV_STBY_TO_RES;
                        end else ill = 1'b1;
                    end
                    ST_DISABLED: begin
                        if (cmd.en) begin
                            nxt      = ST_ENABLED;
                            inst_inc = 1'b1;
                        end else ill = 1'b1;
                    end
                    ST_ENABLED: begin
                        if (cmd.dis)          nxt = ST_DISABLED;
                        else if (cmd.blk)     nxt = ST_BLOCKED;
                        else if (cmd.err_rep) nxt = ST_ERROR;
                        else                  ill = 1'b1;
                    end
                    ST_BLOCKED: begin
                        if (cmd.modify)       nxt = ST_ENABLED;
                        else if (cmd.err_rep) nxt = ST_ERROR;
                        else                  ill = 1'b1;
                    end
                    ST_ERROR: begin
                        if (cmd.modify) nxt = ST_ENABLED;
                        else            ill = 1'b1;
                    end
                    ST_PERM_ERR: ill = 1'b1;
                    default:     ill = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESERVED;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid_q <= 1'b0;
            ev_code_q  <= '0;
            err_q      <= 1'b0;
        end else begin
            ev_valid_q <= ev;
            ev_code_q  <= ev ? code : 16'h0000;
            err_q      <= ill;
        end
    end

endmodule

// File: rtl/fn_lc_timer.sv
module fn_lc_timer #(
    parameter longint unsigned UNPLUG_CYCLES = 64'd60_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic clr,
    output logic pending,
    output logic expire
);

    localparam int CNT_W = $clog2(UNPLUG_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (clr) begin
            pending <= 1'b0;
            cnt     <= '0;
        end else if (arm) begin
            pending <= 1'b1;
            cnt     <= CNT_W'(UNPLUG_CYCLES);
        end else if (pending) begin
            cnt     <= cnt - 1'b1;
        end
    end

    assign expire = pending && (cnt == CNT_W'(1));

endmodule

// File: rtl/fn_lc_handle.sv
module fn_lc_handle
    import fn_lc_pkg::*;
#(
    parameter logic [7:0]  FN_TYPE  = 8'h02,
    parameter logic [15:0] FN_INDEX = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  fn_state_e   state,
    input  logic        inst_inc,
    output logic [31:0] handle
);

    logic [INST_W-1:0] inst_q;
    logic              en_bit;

    always_ff @(posedge clk) begin
        if (!rst_n)        inst_q <= '0;
        else if (inst_inc) inst_q <= inst_q + 1'b1;
    end

    assign en_bit = (state == ST_ENABLED) || (state == ST_BLOCKED) ||
                    (state == ST_ERROR);
    assign handle = {en_bit, inst_q, FN_TYPE, FN_INDEX};

endmodule

// File: rtl/fn_lifecycle_ctrl.sv
module fn_lifecycle_ctrl
    import fn_lc_pkg::*;
#(
    parameter longint unsigned UNPLUG_CYCLES = 64'd60_000_000_000,
    parameter logic [7:0]      FN_TYPE       = 8'h02,
    parameter logic [15:0]     FN_INDEX      = 16'h0005
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        plug_i,
    input  logic        configure_i,
    input  logic        deconfigure_i,
    input  logic        enable_i,
    input  logic        disable_i,
    input  logic        block_i,
    input  logic        modify_i,
    input  logic        err_report_i,
    input  logic        fatal_i,
    input  logic        unplug_i,
    output logic [2:0]  state_o,
    output logic [31:0] handle_o,
    output logic        dma_ok_o,
    output logic        ev_valid_o,
    output logic [15:0] ev_code_o,
    output logic        err_o
);

    fn_cmd_t   cmd;
    fn_state_e state;
    logic      pending, expire, arm, clr, inst_inc;

    assign cmd = '{plug: plug_i, cfg: configure_i, decfg: deconfigure_i,
                   en: enable_i, dis: disable_i, blk: block_i,
                   modify: modify_i, err_rep: err_report_i,
                   fatal: fatal_i, unplug: unplug_i};

    fn_lc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .pending    (pending),
        .expire     (expire),
        .state_q    (state),
        .ev_valid_q (ev_valid_o),
        .ev_code_q  (ev_code_o),
        .err_q      (err_o),
        .arm        (arm),
        .clr        (clr),
        .inst_inc   (inst_inc)
    );

    fn_lc_timer #(.UNPLUG_CYCLES(UNPLUG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .clr     (clr),
        .pending (pending),
        .expire  (expire)
    );

    fn_lc_handle #(.FN_TYPE(FN_TYPE), .FN_INDEX(FN_INDEX)) u_handle (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .inst_inc (inst_inc),
        .handle   (handle_o)
    );

    assign state_o  = state;
    assign dma_ok_o = (state == ST_ENABLED);

endmodule

// File: rtl/fn_lifecycle_ctrl_chk.sv
module fn_lifecycle_ctrl_chk
    import fn_lc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  state_o,
    input logic [31:0] handle_o,
    input logic        dma_ok_o,
    input logic        ev_valid_o,
    input logic [15:0] ev_code_o,
    input logic        err_o
);

    assert_dma_has_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ok_o |-> handle_o[31]);

    assert_enable_bit_states_R6: assert property (@(posedge clk) disable iff (!rst_n)
        handle_o[31] |-> (state_o == ST_ENABLED || state_o == ST_BLOCKED ||
                          state_o == ST_ERROR));

    assert_inst_on_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(handle_o[30:24]) |-> (state_o == ST_ENABLED && $past(state_o) == ST_DISABLED));

    assert_illegal_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(state_o) && !ev_valid_o));

    assert_perm_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_PERM_ERR && state_o != ST_PERM_ERR) |->
            (state_o == ST_STANDBY || state_o == ST_RESERVED));

    assert_plug_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == ST_RESERVED && state_o == ST_STANDBY) |->
            (ev_valid_o && ev_code_o == EV_RES_TO_STBY));

    assert_event_code_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_o |-> (ev_code_o == EV_TO_CONFIGURED || ev_code_o == EV_RES_TO_STBY ||
                        ev_code_o == EV_DECFG_REQ || ev_code_o == EV_CFG_TO_STBY ||
                        ev_code_o == EV_STBY_TO_RES));

endmodule

bind fn_lifecycle_ctrl fn_lifecycle_ctrl_chk u_chk (.*);

// File: tb/fn_lifecycle_ctrl_tb.sv
`timescale 1ns/1ps
module fn_lifecycle_ctrl_tb;
    import fn_lc_pkg::*;

    localparam longint unsigned TMO = 64'd20;
    localparam logic [7:0]  TYP = 8'h01;
    localparam logic [15:0] IDX = 16'h0A5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    fn_cmd_t cmd = '0;
    logic [2:0]  state_o;
    logic [31:0] handle_o;
    logic        dma_ok_o, ev_valid_o, err_o;
    logic [15:0] ev_code_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_inst = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [2:0]  st;
        logic [31:0] hdl;
        logic        dma;
        logic        evv;
        logic [15:0] code;
        logic        err;
        string       tag;
    } item_t;

    item_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fn_lifecycle_ctrl #(.UNPLUG_CYCLES(TMO), .FN_TYPE(TYP), .FN_INDEX(IDX)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .plug_i(cmd.plug), .configure_i(cmd.cfg), .deconfigure_i(cmd.decfg),
        .enable_i(cmd.en), .disable_i(cmd.dis), .block_i(cmd.blk),
        .modify_i(cmd.modify), .err_report_i(cmd.err_rep), .fatal_i(cmd.fatal),
        .unplug_i(cmd.unplug),
        .state_o(state_o), .handle_o(handle_o), .dma_ok_o(dma_ok_o),
        .ev_valid_o(ev_valid_o), .ev_code_o(ev_code_o), .err_o(err_o)
    );

    function automatic logic [31:0] exp_handle(input fn_state_e s);
        logic en;
        en = (s == ST_ENABLED) || (s == ST_BLOCKED) || (s == ST_ERROR);
        return {en, 7'(exp_inst), TYP, IDX};
    endfunction

    // driver: one strobe per cycle, expected item due after the next rising edge (R13)
    task automatic step(input fn_cmd_t c, input fn_state_e s, input logic e,
                        input logic evv, input logic [15:0] code, input string tag);
        item_t it;
        @(negedge clk);
        cmd = c;
        it.due  = cyc + 1;
        it.st   = s;
        it.hdl  = exp_handle(s);
        it.dma  = (s == ST_ENABLED);
        it.evv  = evv;
        it.code = code;
        it.err  = e;
        it.tag  = tag;
        q.push_back(it);
    endtask

    function automatic fn_cmd_t mk(input string n);
        fn_cmd_t c;
        c = '0;
        case (n)
            "plug":   c.plug    = 1'b1;
            "cfg":    c.cfg     = 1'b1;
            "decfg":  c.decfg   = 1'b1;
            "en":     c.en      = 1'b1;
            "dis":    c.dis     = 1'b1;
            "blk":    c.blk     = 1'b1;
            "mod":    c.modify  = 1'b1;
            "err":    c.err_rep = 1'b1;
            "fatal":  c.fatal   = 1'b1;
            "unplug": c.unplug  = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

    // monitor: pops each item in the cycle it is due
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (state_o !== it.st || handle_o !== it.hdl || dma_ok_o !== it.dma ||
                ev_valid_o !== it.evv || ev_code_o !== it.code || err_o !== it.err) begin
                failures++;
                $display("FAIL %s: got st=%0d hdl=%h dma=%b ev=%b/%h err=%b exp st=%0d hdl=%h dma=%b ev=%b/%h err=%b",
                         it.tag, state_o, handle_o, dma_ok_o, ev_valid_o, ev_code_o, err_o,
                         it.st, it.hdl, it.dma, it.evv, it.code, it.err);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (state_o !== 3'd0 || handle_o !== {1'b0, 7'd0, TYP, IDX} || ev_valid_o !== 1'b0 ||
            err_o !== 1'b0 || dma_ok_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got st=%0d hdl=%h ev=%b err=%b dma=%b exp st=0 hdl=%h",
                     state_o, handle_o, ev_valid_o, err_o, dma_ok_o, {1'b0, 7'd0, TYP, IDX});
        end
        step(mk("en"),    ST_RESERVED, 1, 0, 16'h0,    "R9 enable in reserved");
        step(mk("plug"),  ST_STANDBY,  0, 1, 16'h0302, "R2 plug");
        step(mk("en"),    ST_STANDBY,  1, 0, 16'h0,    "R9 enable in standby");
        step(mk("cfg"),   ST_DISABLED, 0, 1, 16'h0301, "R2 configure");
        step(mk("err"),   ST_DISABLED, 1, 0, 16'h0,    "R9 error report in disabled");
        exp_inst = 1;
        step(mk("en"),    ST_ENABLED,  0, 0, 16'h0,    "R3 R5 R6 enable");
        step(mk("blk"),   ST_BLOCKED,  0, 0, 16'h0,    "R4 R5 block");
        step(mk("blk"),   ST_BLOCKED,  1, 0, 16'h0,    "R9 block in blocked");
        step(mk("mod"),   ST_ENABLED,  0, 0, 16'h0,    "R4 unblock");
        step(mk("err"),   ST_ERROR,    0, 0, 16'h0,    "R4 error report");
        step(mk("mod"),   ST_ENABLED,  0, 0, 16'h0,    "R4 recover");
        step(mk("dis"),   ST_DISABLED, 0, 0, 16'h0,    "R3 disable");
        exp_inst = 2;
        step(mk("en"),    ST_ENABLED,  0, 0, 16'h0,    "R3 instance increments");
        step(mk("en") | mk("blk"), ST_ENABLED, 1, 0, 16'h0, "R9 two strobes");
        step('0,          ST_ENABLED,  0, 0, 16'h0,    "R9 err pulse one cycle");
        step(mk("fatal"), ST_PERM_ERR, 0, 0, 16'h0,    "R7 fatal");
        step(mk("mod"),   ST_PERM_ERR, 1, 0, 16'h0,    "R7 modify in perm error");
        step(mk("en"),    ST_PERM_ERR, 1, 0, 16'h0,    "R7 enable in perm error");
        step(mk("decfg"), ST_STANDBY,  0, 1, 16'h0304, "R7 R8 deconfigure");
        step(mk("unplug"),ST_RESERVED, 0, 1, 16'h0308, "R10 unplug in standby");
        step(mk("plug"),  ST_STANDBY,  0, 1, 16'h0302, "R2 plug again");
        step(mk("cfg"),   ST_DISABLED, 0, 1, 16'h0301, "R2 configure again");
        step(mk("unplug"),ST_DISABLED, 0, 1, 16'h0303, "R11 unplug request");
        step(mk("unplug"),ST_DISABLED, 1, 0, 16'h0,    "R11 second unplug");
        step(mk("decfg"), ST_RESERVED, 0, 1, 16'h0304, "R11 answered release");
        step(mk("plug"),  ST_STANDBY,  0, 1, 16'h0302, "R2 plug third");
        step(mk("cfg"),   ST_DISABLED, 0, 1, 16'h0301, "R2 configure third");
        exp_inst = 3;
        step(mk("en"),    ST_ENABLED,  0, 0, 16'h0,    "R3 enable third");
        step(mk("unplug"),ST_ENABLED,  0, 1, 16'h0303, "R12 unplug request");
        for (int k = 1; k < int'(TMO); k++) begin
            step('0, ST_ENABLED, 0, 0, 16'h0, "R12 waiting");
        end
        step(mk("blk"),   ST_RESERVED, 0, 1, 16'h0304, "R12 forced release");
        step(mk("decfg"), ST_RESERVED, 1, 0, 16'h0,    "R9 deconfigure in reserved");
        step(mk("unplug"),ST_RESERVED, 1, 0, 16'h0,    "R9 unplug in reserved");
        for (int k = 0; k < 25; k++) begin
            step('0, ST_RESERVED, 0, 0, 16'h0, "R12 no second release");
        end
        @(negedge clk);
        cmd = '0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running exp finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule